// File: doc/BRIEF.md
# Gated Sample Capture Controller

This block takes one signed 8-bit converter sample per clock together with an external gate line. It writes samples to a memory-style write port only inside gate intervals. A capture is set up by an arm pulse, which loads the gate polarity, the rate mode, the synchroniser mode, the marking mode and the total number of samples to store. The write address restarts at zero on each arm.

An interval opens only on a gate edge toward the active level, never on a level that is already present. The first sample is stored after a fixed latency that depends on the rate and synchroniser modes. When the gate leaves its active level, storing goes on until the address count reaches the next block boundary. That boundary is 16 samples in base-rate mode and 32 in double-rate mode. Marking mode can then overwrite those overrun samples with the reserved code 0x80, and it keeps real data clear of that code.

Once the programmed total has been stored, the block raises its done flag and blocks any further write, even inside an open interval. The gate is taken through a two-flop synchroniser and then a tapped delay line. The tap sets the latency, so a closing edge is delayed by exactly as much as the opening edge was.

Top module: `gated_capture`

## Requirements
- R1: After reset, and until the first arm pulse, wr_valid_o and done_o stay low whatever the gate does.
- R2: After an arm, nothing is written while no opening edge has been seen, even when the gate is already at its active level at the arm.
- R3: With cfg_active_high_i = 1 a rising gate edge opens an interval and a falling edge closes it; with cfg_active_high_i = 0 a falling edge opens and a rising edge closes.
- R4: Count the first clock edge that samples the gate at its active level as edge 0. The first write of the interval is visible after edge L, where L is 8 (base rate, no synchroniser), 13 (base rate, synchroniser), 16 (double rate, no synchroniser) or 26 (double rate, synchroniser). Double rate is cfg_fast_i = 1 and synchroniser mode is cfg_sync_i = 1.
- R5: Inside an interval one write happens per clock. wr_data_o is sample_i as sampled at the edge that raises that write, and wr_addr_o counts up by one from 0 after each arm.
- R6: The number of in-interval writes equals the number of edges that sampled the gate active. After the interval closes, 1 to B further writes follow, until the total write count is a multiple of B (B = 16 at base rate, 32 at double rate).
- R7: With cfg_mark_i = 1, an in-interval sample equal to 0x80 is stored as 0x81, and every overrun write after a close is stored as 0x80.
- R8: With cfg_mark_i = 0, overrun writes carry the real sample, and 0x80 is stored unchanged.
- R9: When the write count reaches cfg_total_i, done_o rises in the same cycle as the final wr_valid_o, and no later write happens, even with the gate still active.
- R10: An opening edge that falls inside an overrun is ignored. A later opening edge after the overrun has ended starts a new interval with the same latency L, and its addresses continue from the previous count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | One-cycle pulse that loads the configuration and restarts the capture |
| cfg_active_high_i | input | 1 | Gate polarity: 1 = active high, 0 = active low |
| cfg_fast_i | input | 1 | Double-rate mode: selects the longer latencies and 32-sample blocks |
| cfg_sync_i | input | 1 | Synchroniser mode: selects the longer latency of the rate |
| cfg_mark_i | input | 1 | Marking mode enable |
| cfg_total_i | input | CNT_W | Total number of samples to store |
| gate_i | input | 1 | Asynchronous external gate |
| sample_i | input | 8 | Signed converter sample |
| wr_valid_o | output | 1 | Write strobe |
| wr_addr_o | output | CNT_W | Write address, which is the running sample count |
| wr_data_o | output | 8 | Byte to store |
| done_o | output | 1 | Total sample count reached |

## Verification
The assertions assume that arm_i is a single-cycle pulse and that the configuration inputs are steady when it is sampled. They also assume the gate stays at one level long enough for the delay line to settle before an arm, so that no stale edge is left in the line. The bench drives gate, arm and samples only on falling clock edges. Between scenarios it holds the gate inactive for several tens of cycles, and it re-arms only while the gate sits at a steady level.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

  typedef enum logic [2:0] {
    S_OFF,
    S_WAITOPEN,
    S_REC,
    S_TAIL,
    S_DONE
  } seq_state_t;

  typedef struct packed {
    logic active_high;
    logic fast;
    logic sync;
    logic mark;
  } cfg_t;

  // Delay-line tap for a latency: two synchroniser flops plus output register.
  function automatic int unsigned lat_tap(input logic fast, input logic sync,
                                          input int unsigned l_b, input int unsigned l_bs,
                                          input int unsigned l_f, input int unsigned l_fs);
    int unsigned lat;
    case ({fast, sync})
      2'b00:   lat = l_b;
      2'b01:   lat = l_bs;
      2'b10:   lat = l_f;
      default: lat = l_fs;
    endcase
    return lat - 3;
  endfunction

  // True when n is a whole number of blocks.
  function automatic logic on_block_edge(input logic [31:0] n, input logic fast,
                                         input int unsigned lg_b, input int unsigned lg_f);
    logic [31:0] mask;
    mask = (32'd1 << (fast ? lg_f : lg_b)) - 32'd1;
    return (n & mask) == 32'd0;
  endfunction

  // Byte to store for a write.
  function automatic logic [7:0] shape_sample(input logic [7:0] raw, input logic mark,
                                              input logic tail);
    if (mark && tail) return 8'h80;
    if (mark && raw == 8'h80) return 8'h81;
    return raw;
  endfunction

endpackage

// File: rtl/gsc_gate_front.sv
module gsc_gate_front #(
  parameter int DLY_LEN = 32,
  localparam int TAP_W = $clog2(DLY_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_i,
  input  logic             active_high,
  input  logic [TAP_W-1:0] tap,
  output logic             open_evt,
  output logic             close_evt
);

  logic               sync1_q, sync2_q;
  logic [DLY_LEN-1:0] line_q;
  logic [TAP_W-1:0]   tap_old;
  logic               act_new, act_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      line_q  <= '0;
    end else begin
      sync1_q <= gate_i;
      sync2_q <= sync1_q;
      line_q  <= {line_q[DLY_LEN-2:0], sync2_q};
    end
  end

  always_comb begin
    tap_old   = tap + 1'b1;
    act_new   = active_high ? line_q[tap] : ~line_q[tap];
    act_old   = active_high ? line_q[tap_old] : ~line_q[tap_old];
    open_evt  = act_new & ~act_old;
    close_evt = ~act_new & act_old;
  end

  // R3
  open_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_evt |=> !open_evt);

endmodule

// File: rtl/gsc_seq.sv
module gsc_seq import gsc_pkg::*; #(
  parameter int CNT_W       = 20,
  parameter int BLK_LG_BASE = 4,
  parameter int BLK_LG_FAST = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  cfg_t             cfg_in,
  input  logic [CNT_W-1:0] total_in,
  input  logic             open_evt,
  input  logic             close_evt,
  output cfg_t             cfg,
  output logic             write_now,
  output logic             tail_now,
  output logic [CNT_W-1:0] index,
  output logic             armed,
  output logic             done
);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] count_q, count_nx, total_q;
  cfg_t             cfg_q;
  logic             last_write, blk_end;

  always_comb begin
    count_nx   = count_q + 1'b1;
    last_write = (count_nx == total_q);
    blk_end    = on_block_edge(32'(count_nx), cfg_q.fast, BLK_LG_BASE, BLK_LG_FAST);
    write_now  = !arm && ((state_q == S_WAITOPEN && open_evt) ||
                          state_q == S_REC || state_q == S_TAIL);
    tail_now   = (state_q == S_REC && close_evt) || state_q == S_TAIL;
    state_d    = state_q;
    if (write_now) begin
      if (last_write)            state_d = S_DONE;
      else if (tail_now && blk_end) state_d = S_WAITOPEN;
      else if (tail_now)         state_d = S_TAIL;
      else                       state_d = S_REC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OFF;
      count_q <= '0;
      total_q <= '0;
      cfg_q   <= '0;
    end else if (arm) begin
      cfg_q   <= cfg_in;
      total_q <= total_in;
      count_q <= '0;
      state_q <= (total_in == '0) ? S_DONE : S_WAITOPEN;
    end else begin
      state_q <= state_d;
      if (write_now) count_q <= count_nx;
    end
  end

  assign cfg   = cfg_q;
  assign index = count_q;
  assign armed = (state_q != S_OFF);
  assign done  = (state_q == S_DONE);

  logic [31:0] blk_mask;
  assign blk_mask = (32'd1 << (cfg_q.fast ? BLK_LG_FAST : BLK_LG_BASE)) - 32'd1;

  // R6
  block_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAITOPEN && ($past(state_q) == S_TAIL || $past(state_q) == S_REC))
      |-> ((32'(count_q) & blk_mask) == 32'd0));

  // R9
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (count_q <= total_q));

endmodule

// File: rtl/gsc_out.sv
module gsc_out import gsc_pkg::*; #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             write_now,
  input  logic             tail_now,
  input  logic [CNT_W-1:0] index,
  input  logic [7:0]       sample,
  input  logic             mark,
  output logic             wr_valid,
  output logic [CNT_W-1:0] wr_addr,
  output logic [7:0]       wr_data
);

  logic wr_tail_q, wr_mark_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_tail_q <= 1'b0;
      wr_mark_q <= 1'b0;
    end else begin
      wr_valid  <= write_now;
      wr_tail_q <= tail_now;
      wr_mark_q <= mark;
      if (write_now) begin
        wr_addr <= index;
        wr_data <= shape_sample(sample, mark, tail_now);
      end
    end
  end

  // R7
  marker_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_mark_q && !wr_tail_q) |-> (wr_data != 8'h80));

endmodule

// File: rtl/gated_capture.sv
module gated_capture import gsc_pkg::*; #(
  parameter int CNT_W         = 20,
  parameter int LAT_BASE      = 8,
  parameter int LAT_BASE_SYNC = 13,
  parameter int LAT_FAST      = 16,
  parameter int LAT_FAST_SYNC = 26,
  parameter int BLK_LG_BASE   = 4,
  parameter int BLK_LG_FAST   = 5,
  parameter int DLY_LEN       = 32,
  localparam int TAP_W = $clog2(DLY_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             cfg_active_high_i,
  input  logic             cfg_fast_i,
  input  logic             cfg_sync_i,
  input  logic             cfg_mark_i,
  input  logic [CNT_W-1:0] cfg_total_i,
  input  logic             gate_i,
  input  logic [7:0]       sample_i,
  output logic             wr_valid_o,
  output logic [CNT_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic             done_o
);

  cfg_t             cfg_in, cfg;
  logic             open_evt, close_evt;
  logic             write_now, tail_now, armed;
  logic [CNT_W-1:0] index;
  logic [TAP_W-1:0] tap;

  assign cfg_in = '{active_high: cfg_active_high_i, fast: cfg_fast_i,
                    sync: cfg_sync_i, mark: cfg_mark_i};
  assign tap = TAP_W'(lat_tap(cfg.fast, cfg.sync, LAT_BASE, LAT_BASE_SYNC,
                              LAT_FAST, LAT_FAST_SYNC));

  gsc_gate_front #(.DLY_LEN(DLY_LEN)) u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_i     (gate_i),
    .active_high(cfg.active_high),
    .tap        (tap),
    .open_evt   (open_evt),
    .close_evt  (close_evt)
  );

  gsc_seq #(.CNT_W(CNT_W), .BLK_LG_BASE(BLK_LG_BASE), .BLK_LG_FAST(BLK_LG_FAST)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm_i),
    .cfg_in   (cfg_in),
    .total_in (cfg_total_i),
    .open_evt (open_evt),
    .close_evt(close_evt),
    .cfg      (cfg),
    .write_now(write_now),
    .tail_now (tail_now),
    .index    (index),
    .armed    (armed),
    .done     (done_o)
  );

  gsc_out #(.CNT_W(CNT_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .write_now(write_now),
    .tail_now (tail_now),
    .index    (index),
    .sample   (sample_i),
    .mark     (cfg.mark),
    .wr_valid (wr_valid_o),
    .wr_addr  (wr_addr_o),
    .wr_data  (wr_data_o)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !wr_valid_o);

  // R9
  done_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !arm_i) |=> !wr_valid_o);

endmodule

// File: tb/sim_gated_capture.sv
module sim_gated_capture;
  localparam int CW = 20;

  logic          clk = 1'b0, rst_n = 1'b0, arm = 1'b0;
  logic          pol = 1'b1, fast = 1'b0, syn = 1'b0, mark = 1'b0;
  logic [CW-1:0] total = '0;
  logic          gate = 1'b0;
  logic [7:0]    smp = 8'h00;
  logic          wr_valid, done;
  logic [CW-1:0] wr_addr;
  logic [7:0]    wr_data;
  int            n_chk = 0, n_bad = 0, nclk = 0;
  bit            finished = 0;

  gated_capture u0 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .cfg_active_high_i(pol), .cfg_fast_i(fast),
    .cfg_sync_i(syn), .cfg_mark_i(mark), .cfg_total_i(total), .gate_i(gate),
    .sample_i(smp), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .done_o(done)
  );

  always #4 clk = ~clk;

  // new sample each falling edge, 0x80 every fourth cycle
  always @(negedge clk) begin
    nclk <= nclk + 1;
    smp  <= (nclk % 4 == 1) ? 8'h80 : 8'(nclk * 29 + 3);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] clip(input logic [7:0] raw, input bit mk);
    return (mk && raw == 8'h80) ? 8'h81 : raw;
  endfunction

  task automatic arm_cfg(input bit p, input bit f, input bit s, input bit mk, input int tot);
    @(negedge clk);
    pol <= p; fast <= f; syn <= s; mark <= mk; total <= CW'(tot); arm <= 1'b1;
    @(negedge clk);
    arm <= 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one gate interval of g edges; checks latency, addresses, data and overrun
  task automatic run_interval(input int g, input int c0, input bit act, input int lat,
                              input int blk, input bit mk, input string tag);
    int j = 0;
    int tail;
    logic [7:0] exp;
    tail = blk - ((c0 + g) % blk);
    @(negedge clk);
    gate <= act;
    for (int i = 1; i <= g + lat + blk + 8; i++) begin
      @(negedge clk);
      if (i == g) gate <= ~act;
      if (wr_valid) begin
        if (j == 0) chk(i == lat + 1, {tag, " R4 latency"}, i - 1, lat);
        chk(wr_addr == CW'(c0 + j), {tag, " R5 address"}, int'(wr_addr), c0 + j);
        exp = (j < g) ? clip(smp, mk) : (mk ? 8'h80 : smp);
        chk(wr_data == exp, (j < g) ? {tag, " R5/R7 data"} : (mk ? {tag, " R7 marker"}
            : {tag, " R8 overrun data"}), int'(wr_data), int'(exp));
        j++;
      end
    end
    chk(j == g + tail, {tag, " R6 write count"}, j, g + tail);
  endtask

  task automatic t_reset;
    int bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i % 7 == 0) gate <= ~gate;
      if (wr_valid || done) bad++;
    end
    chk(bad == 0, "R1 quiet before arm", bad, 0);
    gate <= 1'b0;
    idle(40);
  endtask

  task automatic t_level_no_start;
    int n = 0;
    @(negedge clk); gate <= 1'b1;
    idle(40);
    arm_cfg(1, 0, 0, 0, 20'hFFFFF);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (wr_valid) n++;
    end
    chk(n == 0, "R2 active level at arm", n, 0);
    gate <= 1'b0;
    idle(40);
    run_interval(20, 0, 1'b1, 8, 16, 1'b0, "high/base");
    run_interval(16, 32, 1'b1, 8, 16, 1'b0, "high/base again");
  endtask

  task automatic t_active_low;
    @(negedge clk); gate <= 1'b1;
    idle(40);
    arm_cfg(0, 0, 1, 1, 20'hFFFFF);
    run_interval(7, 0, 1'b0, 13, 16, 1'b1, "R3 low/sync");
    idle(20);
  endtask

  task automatic t_fast;
    arm_cfg(0, 1, 1, 1, 20'hFFFFF);
    run_interval(40, 0, 1'b0, 26, 32, 1'b1, "fast/sync");
    idle(20);
    arm_cfg(0, 1, 0, 1, 20'hFFFFF);
    run_interval(40, 0, 1'b0, 16, 32, 1'b1, "fast");
    run_interval(5, 64, 1'b0, 16, 32, 1'b1, "fast second");
    @(negedge clk); gate <= 1'b0;
    idle(40);
  endtask

  task automatic t_done;
    int j = 0, extra = 0;
    arm_cfg(1, 0, 0, 0, 20);
    @(negedge clk); gate <= 1'b1;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if (wr_valid) begin
        if (j == 0) chk(!done, "R9 done low early", int'(done), 0);
        if (j == 19) chk(done, "R9 done with last write", int'(done), 1);
        if (j >= 20) extra++;
        j++;
      end
    end
    chk(j == 20, "R9 total writes", j, 20);
    chk(extra == 0, "R9 no write after done", extra, 0);
    chk(done, "R9 done held", int'(done), 1);
    gate <= 1'b0;
    idle(40);
  endtask

  task automatic t_reopen;
    int n = 0;
    arm_cfg(1, 0, 0, 1, 20'hFFFFF);
    @(negedge clk); gate <= 1'b1;
    for (int i = 1; i <= 90; i++) begin
      @(negedge clk);
      if (i == 5) gate <= 1'b0;
      if (i == 8) gate <= 1'b1;
      if (wr_valid) n++;
    end
    chk(n == 16, "R10 reopen in overrun ignored", n, 16);
    gate <= 1'b0;
    idle(40);
    run_interval(3, 16, 1'b1, 8, 16, 1'b1, "R10 next interval");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_valid && !done, "R1 reset state", int'(wr_valid), 0);
    rst_n <= 1'b1;
    t_reset();
    t_level_no_start();
    t_active_low();
    t_fast();
    t_done();
    t_reopen();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule